// File: doc/BRIEF.md
# Speculative Store Buffer with Load Forwarding

This block holds the results of store instructions that have executed but not yet committed, so that the data cache only ever sees stores that are architecturally final. An executed store claims the next free slot. The slot records the store's instruction tag, its word address and its data, and it starts out speculative. Commit and abort requests carry an instruction tag and act on the matching speculative slot. Commit turns the slot into a final store. Abort discards it.

Committed stores leave through a drain port towards the data cache, oldest first. At most one store leaves per cycle, and a store leaves only when the cache accepts it. Stores are assumed to execute in program order relative to each other, so slot allocation order is program order.

A load lookup port searches the buffer in the same cycle. A store can serve the load when its address equals the load's address and it is older than the load. Of the stores that qualify, the most recent one in program order supplies the data. If no store qualifies, the cache word supplied with the lookup is passed through and the miss is flagged. Age between a speculative store and a load comes from their tags. Tags wrap modulo twice the buffer depth and are measured from the tag of the oldest instruction still in flight.

Top module: `spec_store_buffer`

## Requirements
- R1: After reset the buffer is empty: `exe_ready` is 1, `drn_valid` is 0 and `lkp_hit` is 0.
- R2: A store accepted on the execute port (`exe_valid` and `exe_ready` both 1 at a clock edge) is held as speculative. `drn_valid` is never 1 while the oldest held store is speculative.
- R3: A commit request whose `cmt_tag` equals the tag of a held speculative store makes that store non-speculative. If it is the oldest held store, `drn_valid` rises in the next cycle.
- R4: An abort request whose `abt_tag` equals the tag of a held speculative store discards it. From the next cycle it never forwards and is never drained.
- R5: Committed stores drain in the order they were accepted. The oldest one is presented with `drn_addr` and `drn_data`, and it stays presented unchanged until `drn_ready` is 1. After acceptance it is freed and the next store can appear in the next cycle.
- R6: The buffer holds at most DEPTH stores, and `exe_ready` is 0 exactly when DEPTH slots are occupied. A discarded store keeps its slot until it reaches the oldest position, where it is released in one cycle without a drain.
- R7: On a lookup (`lkp_valid` = 1), `lkp_hit` is 1 when some held store has the same address and is older than the load. `lkp_data` is then the data of the most recently accepted such store, whatever the cache word is.
- R8: A committed store is always older than the load. A speculative store with tag S is older than a load with tag L when (S − O) mod 2·DEPTH < (L − O) mod 2·DEPTH, where O is `oldest_tag`.
- R9: When no held store qualifies, or `lkp_valid` is 0, `lkp_hit` is 0 and `lkp_data` equals `lkp_cache_data`.
- R10: Addresses are compared over all ADDR_W bits. A store differing from the load address in any bit does not forward.
- R11: A store accepted in the same cycle as a lookup is not visible to that lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exe_valid | input | 1 | Executed store offered |
| exe_ready | output | 1 | A slot is free |
| exe_tag | input | TAG_W | Instruction tag of the store |
| exe_addr | input | ADDR_W | Word address of the store |
| exe_data | input | DATA_W | Store data |
| cmt_valid | input | 1 | Commit request |
| cmt_tag | input | TAG_W | Tag of the committing store |
| abt_valid | input | 1 | Abort request |
| abt_tag | input | TAG_W | Tag of the aborted store |
| oldest_tag | input | TAG_W | Tag of the oldest in-flight instruction |
| drn_valid | output | 1 | Committed store offered to the cache |
| drn_ready | input | 1 | Cache accepts the offered store |
| drn_addr | output | ADDR_W | Address of the offered store |
| drn_data | output | DATA_W | Data of the offered store |
| lkp_valid | input | 1 | Load lookup request |
| lkp_addr | input | ADDR_W | Load word address |
| lkp_tag | input | TAG_W | Instruction tag of the load |
| lkp_cache_data | input | DATA_W | Word read from the cache for this load |
| lkp_hit | output | 1 | Load served from the buffer |
| lkp_data | output | DATA_W | Data returned to the load |

## Verification
The bench builds the buffer with DEPTH = 4, ADDR_W = 8 and DATA_W = 16. That makes the tag only three bits wide, so tag wrap-around occurs every eight instructions and the modular age rule is exercised many times. Only four slots are available, so the full stall and the release of discarded slots come up often. Loads and stores use only four low addresses, so several stores to the same word are regularly in flight together and the newest-older selection is tested. Some addresses differ from these only in the top bit, which tests the full-width address match.

// File: rtl/ssb_pkg.sv
// Shared helpers for the speculative store buffer.
// Assumes tags are at most 16 bits wide.
package ssb_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    // Distance of a tag from a base tag in the wrapping tag space.
    function automatic logic [15:0] tag_distance(
        input logic [15:0] tag,
        input logic [15:0] base,
        input logic [15:0] mask
    );
        return (tag - base) & mask;
    endfunction
endpackage

// File: rtl/ssb_queue_ctrl.sv
// Head/tail control of the slot ring. Slots are allocated in execute order.
// Committed slots are drained from the head, and discarded slots are skipped at the head.
// Assumes DEPTH is a power of two and at least 2.
module ssb_queue_ctrl #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_req,
    input  logic             head_vld,
    input  logic             head_spec,
    input  logic             drn_ready,
    output logic             alloc_ok,
    output logic             alloc_fire,
    output logic             drn_valid,
    output logic             drn_fire,
    output logic [IDX_W-1:0] head_idx,
    output logic [IDX_W-1:0] tail_idx,
    output logic [CNT_W-1:0] occupancy
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [CNT_W-1:0] head_q;
    logic [CNT_W-1:0] tail_q;
    logic             empty;
    logic             skip_hole;
    logic             pop;

    // Derive occupancy, drain offer and pop/allocate decisions.
    always_comb begin
        occupancy  = tail_q - head_q;
        empty      = (occupancy == '0);
        alloc_ok   = (occupancy != CNT_W'(DEPTH));
        alloc_fire = alloc_req && alloc_ok;
        drn_valid  = !empty && head_vld && !head_spec;
        drn_fire   = drn_valid && drn_ready;
        skip_hole  = !empty && !head_vld;
        pop        = drn_fire || skip_hole;
        head_idx   = head_q[IDX_W-1:0];
        tail_idx   = tail_q[IDX_W-1:0];
    end

    // Advance the ring pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (pop) begin
                head_q <= head_q + CNT_W'(1);
            end
            if (alloc_fire) begin
                tail_q <= tail_q + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/ssb_entry_file.sv
// Slot storage. Each slot holds valid, speculative, tag, address and data.
// Commit and abort match only valid speculative slots. Assumes in-flight tags are unique.
module ssb_entry_file #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int TAG_W = IDX_W + 1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               alloc_fire,
    input  logic [IDX_W-1:0]                   tail_idx,
    input  logic [TAG_W-1:0]                   exe_tag,
    input  logic [ADDR_W-1:0]                  exe_addr,
    input  logic [DATA_W-1:0]                  exe_data,
    input  logic                               cmt_valid,
    input  logic [TAG_W-1:0]                   cmt_tag,
    input  logic                               abt_valid,
    input  logic [TAG_W-1:0]                   abt_tag,
    input  logic                               drn_fire,
    input  logic [IDX_W-1:0]                   head_idx,
    output logic [DEPTH-1:0]                   ent_vld,
    output logic [DEPTH-1:0]                   ent_spec,
    output logic [DEPTH-1:0][TAG_W-1:0]        ent_tag,
    output logic [DEPTH-1:0][ADDR_W-1:0]       ent_addr,
    output logic [DEPTH-1:0][DATA_W-1:0]       ent_data
);
    timeunit 1ns;
    timeprecision 1ps;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic              vld_q;
        logic              spec_q;
        logic [TAG_W-1:0]  tag_q;
        logic [ADDR_W-1:0] addr_q;
        logic [DATA_W-1:0] data_q;
        logic              wr_here;
        logic              cmt_here;
        logic              abt_here;
        logic              free_here;

        // Decode the events that touch this slot.
        always_comb begin
            wr_here   = alloc_fire && (tail_idx == IDX_W'(i));
            cmt_here  = cmt_valid && vld_q && spec_q && (tag_q == cmt_tag);
            abt_here  = abt_valid && vld_q && spec_q && (tag_q == abt_tag);
            free_here = drn_fire && (head_idx == IDX_W'(i));
        end

        // Update the status bits of this slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q  <= 1'b0;
                spec_q <= 1'b0;
            end else if (wr_here) begin
                vld_q  <= 1'b1;
                spec_q <= 1'b1;
            end else begin
                if (abt_here || free_here) begin
                    vld_q <= 1'b0;
                end
                if (cmt_here) begin
                    spec_q <= 1'b0;
                end
            end
        end

        // Capture the payload of an accepted store.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_q  <= '0;
                addr_q <= '0;
                data_q <= '0;
            end else if (wr_here) begin
                tag_q  <= exe_tag;
                addr_q <= exe_addr;
                data_q <= exe_data;
            end
        end

        assign ent_vld[i]  = vld_q;
        assign ent_spec[i] = spec_q;
        assign ent_tag[i]  = tag_q;
        assign ent_addr[i] = addr_q;
        assign ent_data[i] = data_q;
    end
endmodule

// File: rtl/ssb_fwd_mux.sv
// Load forwarding. Scans slots from oldest to newest. The last slot that matches the
// address and is older than the load wins. Otherwise the cache word passes through.
// Assumes ring order equals program order.
module ssb_fwd_mux #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int TAG_W = IDX_W + 1
) (
    input  logic [DEPTH-1:0]             ent_vld,
    input  logic [DEPTH-1:0]             ent_spec,
    input  logic [DEPTH-1:0][TAG_W-1:0]  ent_tag,
    input  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr,
    input  logic [DEPTH-1:0][DATA_W-1:0] ent_data,
    input  logic [IDX_W-1:0]             head_idx,
    input  logic [TAG_W-1:0]             oldest_tag,
    input  logic                         lkp_valid,
    input  logic [ADDR_W-1:0]            lkp_addr,
    input  logic [TAG_W-1:0]             lkp_tag,
    input  logic [DATA_W-1:0]            lkp_cache_data,
    output logic                         lkp_hit,
    output logic [DATA_W-1:0]            lkp_data
);
    timeunit 1ns;
    timeprecision 1ps;
    import ssb_pkg::*;

    localparam logic [15:0] TAG_MASK = 16'((1 << TAG_W) - 1);

    logic [IDX_W-1:0]  idx;
    logic [15:0]       load_age;
    logic              any_hit;
    logic [DATA_W-1:0] pick;
    logic              older;

    // Priority scan in ring order. Later (newer) matches override earlier ones.
    always_comb begin
        any_hit  = 1'b0;
        pick     = '0;
        idx      = head_idx;
        older    = 1'b0;
        load_age = tag_distance(16'(lkp_tag), 16'(oldest_tag), TAG_MASK);
        for (int k = 0; k < DEPTH; k++) begin
            idx   = head_idx + IDX_W'(k);
            older = !ent_spec[idx] ||
                    (tag_distance(16'(ent_tag[idx]), 16'(oldest_tag), TAG_MASK) < load_age);
            if (ent_vld[idx] && (ent_addr[idx] == lkp_addr) && older) begin
                any_hit = 1'b1;
                pick    = ent_data[idx];
            end
        end
        lkp_hit  = lkp_valid && any_hit;
        lkp_data = lkp_hit ? pick : lkp_cache_data;
    end
endmodule

// File: rtl/spec_store_buffer.sv
// Speculative store buffer top. Holds executed stores until commit, drains committed
// stores to the cache in order, and forwards data to loads.
// Assumes stores execute in program order and commit before they drain.
module spec_store_buffer #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int TAG_W = IDX_W + 1,
    localparam int CNT_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exe_valid,
    output logic              exe_ready,
    input  logic [TAG_W-1:0]  exe_tag,
    input  logic [ADDR_W-1:0] exe_addr,
    input  logic [DATA_W-1:0] exe_data,
    input  logic              cmt_valid,
    input  logic [TAG_W-1:0]  cmt_tag,
    input  logic              abt_valid,
    input  logic [TAG_W-1:0]  abt_tag,
    input  logic [TAG_W-1:0]  oldest_tag,
    output logic              drn_valid,
    input  logic              drn_ready,
    output logic [ADDR_W-1:0] drn_addr,
    output logic [DATA_W-1:0] drn_data,
    input  logic              lkp_valid,
    input  logic [ADDR_W-1:0] lkp_addr,
    input  logic [TAG_W-1:0]  lkp_tag,
    input  logic [DATA_W-1:0] lkp_cache_data,
    output logic              lkp_hit,
    output logic [DATA_W-1:0] lkp_data
);
    timeunit 1ns;
    timeprecision 1ps;

    logic                         alloc_fire;
    logic                         drn_fire;
    logic [IDX_W-1:0]             head_idx;
    logic [IDX_W-1:0]             tail_idx;
    logic [CNT_W-1:0]             occupancy;
    logic                         head_vld;
    logic                         head_spec;
    logic [DEPTH-1:0]             ent_vld;
    logic [DEPTH-1:0]             ent_spec;
    logic [DEPTH-1:0][TAG_W-1:0]  ent_tag;
    logic [DEPTH-1:0][ADDR_W-1:0] ent_addr;
    logic [DEPTH-1:0][DATA_W-1:0] ent_data;

    // Select the head slot for the drain port.
    always_comb begin
        head_vld  = ent_vld[head_idx];
        head_spec = ent_spec[head_idx];
        drn_addr  = ent_addr[head_idx];
        drn_data  = ent_data[head_idx];
    end

    ssb_queue_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_req  (exe_valid),
        .head_vld   (head_vld),
        .head_spec  (head_spec),
        .drn_ready  (drn_ready),
        .alloc_ok   (exe_ready),
        .alloc_fire (alloc_fire),
        .drn_valid  (drn_valid),
        .drn_fire   (drn_fire),
        .head_idx   (head_idx),
        .tail_idx   (tail_idx),
        .occupancy  (occupancy)
    );

    ssb_entry_file #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_file (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_fire (alloc_fire),
        .tail_idx   (tail_idx),
        .exe_tag    (exe_tag),
        .exe_addr   (exe_addr),
        .exe_data   (exe_data),
        .cmt_valid  (cmt_valid),
        .cmt_tag    (cmt_tag),
        .abt_valid  (abt_valid),
        .abt_tag    (abt_tag),
        .drn_fire   (drn_fire),
        .head_idx   (head_idx),
        .ent_vld    (ent_vld),
        .ent_spec   (ent_spec),
        .ent_tag    (ent_tag),
        .ent_addr   (ent_addr),
        .ent_data   (ent_data)
    );

    ssb_fwd_mux #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fwd (
        .ent_vld        (ent_vld),
        .ent_spec       (ent_spec),
        .ent_tag        (ent_tag),
        .ent_addr       (ent_addr),
        .ent_data       (ent_data),
        .head_idx       (head_idx),
        .oldest_tag     (oldest_tag),
        .lkp_valid      (lkp_valid),
        .lkp_addr       (lkp_addr),
        .lkp_tag        (lkp_tag),
        .lkp_cache_data (lkp_cache_data),
        .lkp_hit        (lkp_hit),
        .lkp_data       (lkp_data)
    );
endmodule

// File: rtl/ssb_checker.sv
// Property checker for the speculative store buffer, bound to the top module.
module ssb_checker #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              exe_ready,
    input logic              drn_valid,
    input logic              drn_ready,
    input logic [ADDR_W-1:0] drn_addr,
    input logic [DATA_W-1:0] drn_data,
    input logic              lkp_hit,
    input logic [CNT_W-1:0]  occupancy,
    input logic [IDX_W-1:0]  head_idx,
    input logic [DEPTH-1:0]  ent_spec
);
    timeunit 1ns;
    timeprecision 1ps;

    AST_DRAIN_ONLY_COMMITTED: assert property (@(posedge clk) disable iff (!rst_n)
        drn_valid |-> !ent_spec[head_idx]); // R2

    AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        drn_valid && !drn_ready |=> drn_valid && $stable(drn_addr) && $stable(drn_data)); // R5

    AST_DRAIN_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        drn_valid |-> occupancy != '0); // R5

    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= CNT_W'(DEPTH)); // R6

    AST_NO_GROW_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        !exe_ready |=> occupancy <= $past(occupancy)); // R6

    AST_NO_HIT_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy == '0 |-> !lkp_hit); // R9
endmodule

bind spec_store_buffer ssb_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .exe_ready (exe_ready),
    .drn_valid (drn_valid),
    .drn_ready (drn_ready),
    .drn_addr  (drn_addr),
    .drn_data  (drn_data),
    .lkp_hit   (lkp_hit),
    .occupancy (occupancy),
    .head_idx  (head_idx),
    .ent_spec  (ent_spec)
);

// File: tb/spec_store_buffer_bench.sv
module spec_store_buffer_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int DEPTH = 4;
    localparam int AW    = 8;
    localparam int DW    = 16;
    localparam int TW    = 3;
    localparam int TMOD  = 2 * DEPTH;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          exe_valid = 1'b0;
    logic          exe_ready;
    logic [TW-1:0] exe_tag = '0;
    logic [AW-1:0] exe_addr = '0;
    logic [DW-1:0] exe_data = '0;
    logic          cmt_valid = 1'b0;
    logic [TW-1:0] cmt_tag = '0;
    logic          abt_valid = 1'b0;
    logic [TW-1:0] abt_tag = '0;
    logic [TW-1:0] oldest_tag = '0;
    logic          drn_valid;
    logic          drn_ready = 1'b0;
    logic [AW-1:0] drn_addr;
    logic [DW-1:0] drn_data;
    logic          lkp_valid = 1'b0;
    logic [AW-1:0] lkp_addr = '0;
    logic [TW-1:0] lkp_tag = '0;
    logic [DW-1:0] lkp_cache_data = '0;
    logic          lkp_hit;
    logic [DW-1:0] lkp_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        int tag;
        int addr;
        int data;
        bit vld;
        bit spec;
    } ment_t;
    ment_t mq[$];

    always #2.5 clk = ~clk;

    spec_store_buffer #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW)) u_spec_store_buffer (
        .clk(clk), .rst_n(rst_n),
        .exe_valid(exe_valid), .exe_ready(exe_ready), .exe_tag(exe_tag),
        .exe_addr(exe_addr), .exe_data(exe_data),
        .cmt_valid(cmt_valid), .cmt_tag(cmt_tag),
        .abt_valid(abt_valid), .abt_tag(abt_tag), .oldest_tag(oldest_tag),
        .drn_valid(drn_valid), .drn_ready(drn_ready), .drn_addr(drn_addr), .drn_data(drn_data),
        .lkp_valid(lkp_valid), .lkp_addr(lkp_addr), .lkp_tag(lkp_tag),
        .lkp_cache_data(lkp_cache_data), .lkp_hit(lkp_hit), .lkp_data(lkp_data)
    );

    function automatic int rel(int t, int base);
        return (t - base) & (TMOD - 1);
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        exe_valid = 1'b0; cmt_valid = 1'b0; abt_valid = 1'b0; lkp_valid = 1'b0;
    endtask

    // Expected outputs from the reference queue and the current inputs.
    task automatic compare();
        bit rdy;
        bit dv;
        bit eh;
        int ed;
        rdy = mq.size() < DEPTH;
        dv  = mq.size() > 0 && mq[0].vld && !mq[0].spec;
        chk("R6", "exe_ready", exe_ready, rdy);
        chk("R2", "drn_valid", drn_valid, dv);
        if (dv) begin
            chk("R5", "drn_addr", drn_addr, mq[0].addr);
            chk("R5", "drn_data", drn_data, mq[0].data);
        end
        eh = 1'b0;
        ed = int'(lkp_cache_data);
        if (lkp_valid) begin
            foreach (mq[i]) begin
                if (mq[i].vld && mq[i].addr == int'(lkp_addr) &&
                    (!mq[i].spec || rel(mq[i].tag, int'(oldest_tag)) < rel(int'(lkp_tag), int'(oldest_tag)))) begin
                    eh = 1'b1;
                    ed = mq[i].data;
                end
            end
        end
        chk("R7", "lkp_hit", lkp_hit, eh);
        chk(eh ? "R7" : "R9", "lkp_data", lkp_data, ed);
    endtask

    // Advance the reference queue by one clock edge.
    task automatic model_update();
        bit pop;
        int sz;
        sz  = mq.size();
        pop = 1'b0;
        if (sz > 0) pop = !mq[0].vld || (!mq[0].spec && drn_ready);
        foreach (mq[i]) begin
            if (mq[i].vld && mq[i].spec) begin
                if (cmt_valid && mq[i].tag == int'(cmt_tag)) mq[i].spec = 1'b0;
                if (abt_valid && mq[i].tag == int'(abt_tag)) mq[i].vld = 1'b0;
            end
        end
        if (pop) void'(mq.pop_front());
        if (exe_valid && sz < DEPTH)
            mq.push_back('{tag: int'(exe_tag), addr: int'(exe_addr), data: int'(exe_data), vld: 1'b1, spec: 1'b1});
    endtask

    task automatic cyc();
        #1;
        compare();
        @(posedge clk);
        if (rst_n) model_update();
        else mq.delete();
        @(negedge clk);
    endtask

    task automatic st(input int t, input int a, input int d);
        exe_valid = 1'b1; exe_tag = TW'(t); exe_addr = AW'(a); exe_data = DW'(d);
    endtask

    task automatic ld(input int a, input int t);
        lkp_valid = 1'b1; lkp_addr = AW'(a); lkp_tag = TW'(t);
    endtask

    task automatic do_reset();
        idle();
        rst_n = 1'b0;
        mq.delete();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int nt;
        int oldest;
        int sq[$];
        lkp_cache_data = 16'hCAFE;
        do_reset();
        // R1: empty after reset
        ld(5, 0);
        #1;
        chk("R1", "exe_ready", exe_ready, 1);
        chk("R1", "drn_valid", drn_valid, 0);
        chk("R1", "lkp_hit", lkp_hit, 0);
        cyc();
        idle();
        oldest_tag = 0;
        drn_ready = 1'b1;
        st(0, 5, 16'h1111); cyc();
        st(1, 5, 16'h2222);
        #1; chk("R2", "drn_valid while speculative", drn_valid, 0);
        cyc(); idle();
        ld(5, 2); #1;
        chk("R7", "newest older store", lkp_data, 16'h2222);
        cyc(); idle();
        ld(5, 1); #1;
        chk("R8", "age selects older store", lkp_data, 16'h1111);
        cyc(); idle();
        ld(6, 1); #1;
        chk("R9", "miss passes cache", lkp_data, 16'hCAFE);
        chk("R9", "miss flag", lkp_hit, 0);
        cyc(); idle();
        drn_ready = 1'b0;
        cmt_valid = 1'b1; cmt_tag = 0; cyc(); idle();
        oldest_tag = 1;
        #1;
        chk("R3", "drain after commit", drn_valid, 1);
        chk("R5", "drain data", drn_data, 16'h1111);
        cyc();
        drn_ready = 1'b1; cyc();
        abt_valid = 1'b1; abt_tag = 1; cyc(); idle();
        oldest_tag = 2;
        ld(5, 2); #1;
        chk("R4", "aborted store not forwarded", lkp_hit, 0);
        cyc(); idle();
        for (int k = 0; k < 4; k++) begin
            st(2 + k, 1 + k, 16'h3000 + k); cyc();
        end
        idle();
        #1; chk("R6", "full stall", exe_ready, 0);
        ld(8'h84, 6); #1;
        chk("R10", "upper address bit differs", lkp_hit, 0);
        cyc(); idle();
        ld(4, 6); #1;
        chk("R10", "full address match", lkp_data, 16'h3003);
        cyc(); idle();
        for (int k = 0; k < 4; k++) begin
            oldest_tag = TW'(2 + k);
            cmt_valid = 1'b1; cmt_tag = TW'(2 + k); cyc();
        end
        idle();
        oldest_tag = 6;
        repeat (6) cyc();
        st(6, 7, 16'hAAAA); ld(7, 7); #1;
        chk("R11", "same-cycle store invisible", lkp_hit, 0);
        cyc(); idle();
        st(7, 7, 16'hBBBB); cyc(); idle();
        ld(7, 0); #1;
        chk("R8", "wrapped load tag", lkp_data, 16'hBBBB);
        cyc(); idle();
        ld(7, 7); #1;
        chk("R8", "older of two speculative", lkp_data, 16'hAAAA);
        cyc(); idle();

        // Random phase with protocol-respecting tags.
        do_reset();
        nt = 0;
        for (int c = 0; c < 4000; c++) begin
            int r;
            idle();
            oldest = (sq.size() > 0) ? sq[0] : nt;
            oldest_tag = TW'(oldest);
            r = int'($urandom % 8);
            if (r < 3 && nt - oldest < 7) begin
                st(nt, int'($urandom % 4), int'($urandom));
                if (mq.size() < DEPTH) begin
                    sq.push_back(nt);
                    nt++;
                end
            end else if (r < 5 && sq.size() > 0) begin
                cmt_valid = 1'b1; cmt_tag = TW'(sq[0]);
                void'(sq.pop_front());
            end else if (r == 5 && sq.size() > 0) begin
                abt_valid = 1'b1; abt_tag = TW'(sq[$]);
                void'(sq.pop_back());
            end
            if ($urandom % 4 != 0) ld(int'($urandom % 4), oldest + int'($urandom % (nt - oldest + 1)));
            lkp_cache_data = DW'($urandom);
            drn_ready = ($urandom % 3) != 0;
            cyc();
        end
        idle();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule